// File: doc/BRIEF.md
# Dual-Topology 8-bit Pseudo-Random Sequence Generator

This block produces a maximal-length pseudo-random sequence from an 8-bit linear feedback shift register whose feedback polynomial is x^8+x^6+x^5+x^4+1. One static input selects the structure that computes the next state. It can be the external-feedback (Fibonacci) form, where one parity bit enters at the bottom of the register, or the in-line (Galois) form, where the outgoing top bit is folded into chosen stages. A second static input selects XOR or XNOR feedback.

Each feedback sense has one state the register can never leave: all zeros for XOR and all ones for XNOR. The synchronous reset therefore loads a seed that depends on the selected sense, so the register starts inside the legal orbit. It then advances one state on every clock edge. The full state is presented on a parallel port, and its top bit is also presented as a serial stream.

Top module: `lfsr8_gen`

## Requirements
- R1: When `rst` is high at a rising clock edge, the state becomes 0xFF if `use_xnor` is 0 and 0x00 if `use_xnor` is 1, whatever the previous state and mode.
- R2: With `mode_galois` = 0, each edge shifts the state one place toward the MSB, and the new bit 0 is the parity of old bits 7, 5, 4 and 3 (taps 8, 6, 5, 4 counted from 1). From 0xFF with XOR feedback the states are 0xFF, 0xFE, 0xFC, 0xF8, 0xF0, 0xE1.
- R3: With `mode_galois` = 1, each edge gives: new bit 0 = old bit 7; new bits 4, 5 and 6 = old bit (i-1) combined with old bit 7; every other bit = old bit (i-1). From 0xFF with XOR feedback the states are 0xFF, 0x8F, 0x6F, 0xDE, 0xCD.
- R4: XNOR feedback inverts each combined bit. After reset, the XNOR state at every step is the bitwise complement of the XOR state at the same step in the same topology.
- R5: From the reset seed, in every mode combination, the register visits 255 distinct states, never the lock-up state, and returns to the seed after exactly 255 edges.
- R6: `serial_out` always equals bit 7 of `state`.
- R7: Over one period, the serial stream of the Galois form is the time reversal, up to a rotation, of the serial stream of the Fibonacci form.
- R8: Reset takes priority over shifting. While `rst` stays high, the state holds the seed on every edge.
- R9: A change of `mode_galois` or `use_xnor` made while `rst` is high takes effect from the next edge: the seed follows the new `use_xnor`, and shifting after release follows the new topology.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, loads the seed |
| mode_galois | input | 1 | 0 = external-feedback form, 1 = in-line form; change only under reset |
| use_xnor | input | 1 | 0 = XOR feedback, 1 = XNOR feedback; change only under reset |
| state | output | 8 | Registered register contents |
| serial_out | output | 1 | Top bit of the register |

## Verification
The bench builds the generator with its default parameters: an 8-bit register and the tap mask for positions 8, 6, 5 and 4. At this size a whole period of 255 states is short. This lets the bench walk the full orbit in all four combinations of topology and feedback sense. It records every state and serial bit, and then checks distinctness, the return to the seed, the complement relation between XOR and XNOR runs, and the reversal relation between the two topologies over complete periods instead of sampled windows.

// File: rtl/lfsr8_pkg.sv
`timescale 1ns/1ps
package lfsr8_pkg;

  typedef enum logic {
    TOPO_FIB = 1'b0,
    TOPO_GAL = 1'b1
  } topo_e;

  // Fill value of the seed: the complement of the lock-up fill
  function automatic logic seed_fill(input logic xnor_fb);
    return ~xnor_fb;
  endfunction

endpackage

// File: rtl/lfsr_seed.sv
`timescale 1ns/1ps
module lfsr_seed #(
  parameter int W = 8
) (
  input  logic         use_xnor,
  output logic [W-1:0] seed
);
  import lfsr8_pkg::*;

  always_comb seed = {W{seed_fill(use_xnor)}};

endmodule

// File: rtl/lfsr_fib_step.sv
`timescale 1ns/1ps
module lfsr_fib_step #(
  parameter int           W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic [W-1:0] cur,
  input  logic         invert,
  output logic [W-1:0] nxt
);
  logic parity;

  always_comb begin
    parity = (^(cur & TAPS)) ^ invert;
    nxt    = {cur[W-2:0], parity};
  end

endmodule

// File: rtl/lfsr_gal_step.sv
`timescale 1ns/1ps
module lfsr_gal_step #(
  parameter int           W    = 8,
  parameter logic [W-1:0] MASK = 8'h71
) (
  input  logic [W-1:0] cur,
  input  logic         invert,
  output logic [W-1:0] nxt
);
  logic top;
  assign top = cur[W-1];

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign nxt[i] = top;
    end else if (MASK[i]) begin : g_tap
      assign nxt[i] = cur[i-1] ^ top ^ invert;
    end else begin : g_pass
      assign nxt[i] = cur[i-1];
    end
  end

endmodule

// File: rtl/lfsr8_gen.sv
`timescale 1ns/1ps
module lfsr8_gen #(
  parameter int           W        = 8,
  parameter logic [W-1:0] FIB_TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_galois,
  input  logic         use_xnor,
  output logic [W-1:0] state,
  output logic         serial_out
);
  import lfsr8_pkg::*;

  // In-line taps realising the same polynomial: tap at bit p-1 maps to bit p
  localparam logic [W-1:0] GAL_MASK = {FIB_TAPS[W-2:0], 1'b1};

  logic [W-1:0] state_q;
  logic [W-1:0] seed;
  logic [W-1:0] fib_nxt;
  logic [W-1:0] gal_nxt;
  logic [W-1:0] nxt;
  topo_e        topo;

  assign topo = topo_e'(mode_galois);

  lfsr_seed #(.W(W)) u_seed (
    .use_xnor (use_xnor),
    .seed     (seed)
  );

  lfsr_fib_step #(.W(W), .TAPS(FIB_TAPS)) u_fib (
    .cur    (state_q),
    .invert (use_xnor),
    .nxt    (fib_nxt)
  );

  lfsr_gal_step #(.W(W), .MASK(GAL_MASK)) u_gal (
    .cur    (state_q),
    .invert (use_xnor),
    .nxt    (gal_nxt)
  );

  always_comb nxt = (topo == TOPO_GAL) ? gal_nxt : fib_nxt;

  always_ff @(posedge clk) begin
    if (rst) state_q <= seed;
    else     state_q <= nxt;
  end

  assign state      = state_q;
  assign serial_out = state_q[W-1];

endmodule

// File: rtl/lfsr8_gen_chk.sv
`timescale 1ns/1ps
module lfsr8_gen_chk #(
  parameter int           W        = 8,
  parameter logic [W-1:0] FIB_TAPS = 8'hB8
) (
  input logic         clk,
  input logic         rst,
  input logic         mode_galois,
  input logic         use_xnor,
  input logic [W-1:0] state,
  input logic         serial_out
);
  localparam logic [W-1:0] GAL_MASK = {FIB_TAPS[W-2:0], 1'b1};

  logic past_valid = 1'b0;
  always_ff @(posedge clk) past_valid <= 1'b1;

  // R1 / R8: an edge with reset high leaves the seed of the sampled sense
  a_r1_seed: assert property (@(posedge clk) disable iff (!past_valid)
    $past(rst) |-> state == {W{~$past(use_xnor)}});

  // R5: the lock-up state is never present outside reset
  a_r5_no_lockup: assert property (@(posedge clk) disable iff (rst)
    state != {W{use_xnor}});

  // R2: external-feedback form shifts toward the MSB
  a_r2_fib_shift: assert property (@(posedge clk) disable iff (rst)
    !mode_galois |=> state[W-1:1] == $past(state[W-2:0]));

  // R2 / R4: bit 0 takes the tap parity, inverted for XNOR
  a_r2_fib_feedback: assert property (@(posedge clk) disable iff (rst)
    !mode_galois |=> state[0] == ($past(^(state & FIB_TAPS)) ^ $past(use_xnor)));

  // R3: in-line form returns the top bit to bit 0
  a_r3_gal_wrap: assert property (@(posedge clk) disable iff (rst)
    mode_galois |=> state[0] == $past(state[W-1]));

  // R3: non-tap stages of the in-line form are a plain shift
  a_r3_gal_pass: assert property (@(posedge clk) disable iff (rst)
    mode_galois |=> ((state ^ {$past(state[W-2:0]), 1'b0}) & ~GAL_MASK) == '0);

  // R9: configuration is held steady outside reset
  a_r9_static_cfg: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mode_galois) && $stable(use_xnor));

  // R6: serial port carries the top bit
  always_ff @(posedge clk) begin
    if (past_valid && !rst) begin
      a_r6_serial: assert (serial_out == state[W-1]);
    end
  end

endmodule

bind lfsr8_gen lfsr8_gen_chk #(.W(W), .FIB_TAPS(FIB_TAPS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_galois (mode_galois),
  .use_xnor    (use_xnor),
  .state       (state),
  .serial_out  (serial_out)
);

// File: tb/lfsr8_gen_test.sv
`timescale 1ns/1ps
module lfsr8_gen_test;

  localparam int W   = 8;
  localparam int LEN = 255;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mode_galois = 1'b0;
  logic         use_xnor = 1'b0;
  logic [W-1:0] state;
  logic         serial_out;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] seq  [4][LEN];
  logic         bits [4][LEN];

  always #2.5 clk = ~clk;

  lfsr8_gen uut (
    .clk         (clk),
    .rst         (rst),
    .mode_galois (mode_galois),
    .use_xnor    (use_xnor),
    .state       (state),
    .serial_out  (serial_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Returns at a falling edge with reset released and the seed loaded
  task automatic apply_reset(input bit g, input bit x);
    @(negedge clk);
    rst = 1'b1; mode_galois = g; use_xnor = x;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset_values();
    apply_reset(1'b0, 1'b0);
    check(state == 8'hFF, "R1 XOR seed", state, 8'hFF);
    check(serial_out == 1'b1, "R6 serial at seed", serial_out, 1);
    apply_reset(1'b1, 1'b1);
    check(state == 8'h00, "R1 XNOR seed", state, 8'h00);
    check(serial_out == 1'b0, "R6 serial at XNOR seed", serial_out, 0);
  endtask

  task automatic t_fib_steps();
    logic [W-1:0] exp [6] = '{8'hFF, 8'hFE, 8'hFC, 8'hF8, 8'hF0, 8'hE1};
    apply_reset(1'b0, 1'b0);
    for (int i = 0; i < 6; i++) begin
      check(state == exp[i], "R2 fibonacci step", state, exp[i]);
      step();
    end
  endtask

  task automatic t_gal_steps();
    logic [W-1:0] exp [5] = '{8'hFF, 8'h8F, 8'h6F, 8'hDE, 8'hCD};
    apply_reset(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) begin
      check(state == exp[i], "R3 galois step", state, exp[i]);
      step();
    end
  endtask

  // Combination index c = {mode_galois, use_xnor}
  task automatic t_full_period(input int c);
    bit seen [256];
    int dups = 0, locks = 0, ser_bad = 0;
    logic [W-1:0] lock;
    for (int k = 0; k < 256; k++) seen[k] = 1'b0;
    apply_reset(c[1], c[0]);
    lock = c[0] ? 8'hFF : 8'h00;
    for (int i = 0; i < LEN; i++) begin
      seq[c][i]  = state;
      bits[c][i] = serial_out;
      if (seen[state]) dups++;
      seen[state] = 1'b1;
      if (state == lock) locks++;
      if (serial_out != state[W-1]) ser_bad++;
      step();
    end
    check(dups == 0, "R5 distinct states", dups, 0);
    check(locks == 0, "R5 lock-up avoided", locks, 0);
    check(state == seq[c][0], "R5 period 255", state, seq[c][0]);
    check(ser_bad == 0, "R6 serial tracks MSB", ser_bad, 0);
  endtask

  task automatic t_xnor_complement();
    for (int g = 0; g < 2; g++) begin
      int bad = 0;
      for (int i = 0; i < LEN; i++)
        if (seq[2*g+1][i] != ~seq[2*g][i]) bad++;
      check(bad == 0, "R4 XNOR is complement of XOR", bad, 0);
    end
  endtask

  task automatic t_reverse();
    int hits = 0;
    for (int k = 0; k < LEN; k++) begin
      bit ok = 1'b1;
      for (int i = 0; i < LEN; i++)
        if (bits[2][i] != bits[0][(k - i + LEN) % LEN]) ok = 1'b0;
      if (ok) hits++;
    end
    check(hits >= 1, "R7 galois stream reverses fibonacci", hits, 1);
  endtask

  task automatic t_reset_priority();
    apply_reset(1'b0, 1'b0);
    repeat (5) step();
    check(state != 8'hFF, "R8 moved off seed", state, 8'hFF);
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      check(state == 8'hFF, "R8 seed held under reset", state, 8'hFF);
    end
    rst = 1'b0;
    step();
    check(state == 8'hFE, "R8 resume after reset", state, 8'hFE);
  endtask

  task automatic t_mode_change();
    apply_reset(1'b0, 1'b0);
    step();
    rst = 1'b1;
    step();
    check(state == 8'hFF, "R9 seed before change", state, 8'hFF);
    use_xnor = 1'b1; mode_galois = 1'b1;
    step();
    check(state == 8'h00, "R9 seed follows new sense", state, 8'h00);
    rst = 1'b0;
    step();
    // In-line XNOR from 0x00: taps 4,5,6 become 1, bit 0 stays 0
    check(state == 8'h70, "R9 new topology after release", state, 8'h70);
  endtask

  initial begin
    t_reset_values();
    t_fib_steps();
    t_gal_steps();
    for (int c = 0; c < 4; c++) t_full_period(c);
    t_xnor_complement();
    t_reverse();
    t_reset_priority();
    t_mode_change();
    summary();
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL R5 watchdog expired actual=%0h expected=%0h", 0, 1);
    summary();
    $finish;
  end

endmodule